// File: doc/BRIEF.md
# Flash Command-Register Sequencer

This block is the device-side command interface of a byte-wide, electrically erasable nonvolatile memory. A host drives active-low chip-enable, output-enable and write-enable strobes together with a 17-bit address and an 8-bit data bus. The data bus is split into an input, an output and an output-enable. Each write-enable pulse is a command write. The block decodes it and moves between read, erase set-up, erase, erase verify, program set-up, program and program verify.

Erase and program each need two writes: a set-up write and then an execute write. The operation starts on the rising edge of write enable in the execute write. It ends on the rising edge of the next write pulse, which normally carries a verify command. That verify command also switches reads into margin mode.

A small behavioural byte array stands in for the cells. It is indexed by the low `ARR_AW` address bits. Erase sets every byte to FFH. Program can only clear bits. The high-voltage enable input gates every change to the array. The strobes are sampled on a system clock, and the edges of write enable are detected from the sampled value.

Top module: `flash_cmd_fsm`

## Requirements
- R1: A write pulse counts only if chip enable is low when write enable is sampled falling. The address is captured at that falling sample. The data byte is taken at the rising sample, so an address change while write enable is low has no effect.
- R2: A 20H write leads to erase set-up. A second 20H write starts erase (`erase_on` high) from its rising sample. Any other byte written in erase set-up is decoded as a fresh command.
- R3: Erase (`erase_on`) stays high until the next rising sample of write enable. The command carried by that write is decoded normally.
- R4: An A0H write selects erase verify and captures the byte address sent with it. Reads then return that byte whatever the address bus holds, with `margin_rd` high.
- R5: A 40H write selects program set-up. The next write supplies the address and data and starts programming (`prog_on` high). The addressed byte becomes its old value ANDed with the data.
- R6: A C0H write ends programming and selects program verify with `margin_rd` high. It captures no new address. Reads return the byte last programmed.
- R7: While `hv_en` is low, erase and program still move through their modes, but the array is left unchanged.
- R8: `dq_oe` is low whenever `ce_n` or `oe_n` is high. Outside the verify modes, a read returns the array byte at the low `ARR_AW` bits of `addr`.
- R9: Any byte other than 20H, A0H, 40H and C0H (written outside program set-up) returns the block to read mode. Reset also puts it in read mode, with every array byte at FFH.
- R10: An erase start with `hv_en` high sets every array byte to FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hv_en | input | 1 | High-voltage present; permits array changes |
| addr | input | 17 | Byte address |
| dq_in | input | 8 | Data/command in |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Drive enable for the data bus |
| erase_on | output | 1 | Erase operation active |
| prog_on | output | 1 | Program operation active |
| margin_rd | output | 1 | Reads are margin-verify reads |

## Verification
The rising sample of write enable changes the mode and the array in one cycle. A read with output enable held low can land in the cycle right after it. The bench keeps `oe_n` low across chosen command writes and samples the data bus in the first half-cycle after the rising sample. It expects the byte for the new mode: a freshly programmed value, a captured verify address, or FFH after an erase. These expected values come from a bench model of the mode sequence and the array. Random command streams with random addresses, data and high-voltage levels run alongside this directed case.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int ARR_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hv_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              erase_on,
  output logic              prog_on,
  output logic              margin_rd
);
  localparam int DEPTH = 1 << ARR_AW;
  localparam logic [DATA_W-1:0] C_ERASE = DATA_W'(8'h20);
  localparam logic [DATA_W-1:0] C_EVFY  = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] C_PROG  = DATA_W'(8'h40);
  localparam logic [DATA_W-1:0] C_PVFY  = DATA_W'(8'hC0);

  typedef enum logic [2:0] {S_READ, S_ESU, S_ERASE, S_EVFY, S_PSU, S_PROG, S_PVFY} st_t;

  st_t               st;
  logic              we_q, wr_arm;
  logic [ARR_AW-1:0] a_lat, p_adr, v_adr;
  logic [DATA_W-1:0] mem [DEPTH];

  wire we_fall = we_q & ~we_n & ~ce_n;
  wire we_rise = ~we_q & we_n & wr_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_READ;
      we_q   <= 1'b1;
      wr_arm <= 1'b0;
      a_lat  <= '0;
      p_adr  <= '0;
      v_adr  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      we_q <= we_n;
      if (we_fall) begin
        a_lat  <= addr[ARR_AW-1:0];
        wr_arm <= 1'b1;
      end
      if (we_rise) begin
        wr_arm <= 1'b0;
        if (st == S_PSU) begin
          st    <= S_PROG;
          p_adr <= a_lat;
          if (hv_en) mem[a_lat] <= mem[a_lat] & dq_in;
        end else if (st == S_ESU && dq_in == C_ERASE) begin
          st <= S_ERASE;
          if (hv_en) for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
          case (dq_in)
            C_ERASE: st <= S_ESU;
            C_EVFY: begin st <= S_EVFY; v_adr <= a_lat; end
            C_PROG:  st <= S_PSU;
            C_PVFY: begin st <= S_PVFY; v_adr <= p_adr; end
            default: st <= S_READ;
          endcase
        end
      end
    end
  end

  assign margin_rd = (st == S_EVFY) || (st == S_PVFY);
  assign erase_on  = (st == S_ERASE);
  assign prog_on   = (st == S_PROG);
  assign dq_oe     = ~ce_n & ~oe_n;
  assign dq_out    = margin_rd ? mem[v_adr] : mem[addr[ARR_AW-1:0]];

  assert_addr_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we_fall |=> a_lat == $past(addr[ARR_AW-1:0]));

  assert_erase_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rise && st == S_ESU && dq_in == C_ERASE) |=> erase_on);

  assert_erase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_on && !we_rise) |=> erase_on);

  assert_pvfy_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rise && st != S_PSU && dq_in == C_PVFY) |=> (margin_rd && v_adr == $past(p_adr)));

  assert_hv_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rise && st == S_PSU && !hv_en) |=> mem[$past(a_lat)] == $past(mem[a_lat]));

  assert_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (!oe_n && !ce_n));

  assert_erase_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rise && st == S_ESU && dq_in == C_ERASE && hv_en) |=> mem[$past(addr[ARR_AW-1:0])] == '1);
endmodule

// File: tb/tb_flash_cmd_fsm.sv
module tb_flash_cmd_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int MW = 8;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, hv_en = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic dq_oe, erase_on, prog_on, margin_rd;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  flash_cmd_fsm dut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hv_en(hv_en), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .erase_on(erase_on), .prog_on(prog_on), .margin_rd(margin_rd));

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model: 0 read,1 esu,2 erase,3 evfy,4 psu,5 prog,6 pvfy
  int m_st = 0;
  logic [7:0] m_mem [256];
  logic [7:0] m_v, m_p;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [AW-1:0] a);
    return (m_st == 3 || m_st == 6) ? m_mem[m_v] : m_mem[a[7:0]];
  endfunction

  task automatic model_wr(logic [7:0] a, logic [7:0] d, logic hv);
    if (m_st == 4) begin
      m_st = 5; m_p = a;
      if (hv) m_mem[a] = m_mem[a] & d;
    end else if (m_st == 1 && d == 8'h20) begin
      m_st = 2;
      if (hv) for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
    end else begin
      case (d)
        8'h20: m_st = 1;
        8'hA0: begin m_st = 3; m_v = a; end
        8'h40: m_st = 4;
        8'hC0: begin m_st = 6; m_v = m_p; end
        default: m_st = 0;
      endcase
    end
  endtask

  // one write pulse; address scrambled after the falling sample (R1)
  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); ce_n = 0; addr = a; we_n = 0;
    @(negedge clk); we_n = 1; dq_in = d; addr = AW'($urandom);
    @(posedge clk);
    model_wr(a[7:0], d, hv_en);
    @(negedge clk); ce_n = oe_n ? 1'b1 : 1'b0;
  endtask

  task automatic rd(string req, logic [AW-1:0] a);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a; #1;
    chk(req, dq_out, exp_rd(a));
    chk("R8 dq_oe", dq_oe, 1);
    chk("R4/R6 margin_rd", margin_rd, (m_st == 3 || m_st == 6));
    chk("R2/R3 erase_on", erase_on, m_st == 2);
    chk("R5 prog_on", prog_on, m_st == 5);
    oe_n = 1; ce_n = 1;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual %0d expected <150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
    m_v = 0; m_p = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset erase_on", erase_on, 0);
    chk("R9 reset prog_on", prog_on, 0);
    chk("R9 reset margin", margin_rd, 0);
    chk("R8 float at reset", dq_oe, 0);
    @(negedge clk); rst_n = 1;
    rd("R9 reset array FF", 17'h00033);

    // program, verify (R5, R6)
    wr(17'h0, 8'h40); wr(17'h1_0005, 8'hA5);
    rd("R5 program active", 17'h5);
    wr(17'h0, 8'hC0);
    rd("R6 verify last programmed", 17'h77);
    wr(17'h0, 8'h40); wr(17'h5, 8'h0F); wr(17'h0, 8'hC0);
    rd("R5 program ANDs", 17'h9);
    // write with ce_n high ignored (R1)
    @(negedge clk); ce_n = 1; we_n = 0; addr = 17'h5;
    @(negedge clk); we_n = 1; dq_in = 8'h55;
    @(negedge clk);
    rd("R1 ce_n high write ignored", 17'h5);
    // float with oe_n or ce_n high (R8)
    @(negedge clk); ce_n = 0; oe_n = 1; #1; chk("R8 oe_n high float", dq_oe, 0);
    ce_n = 1; oe_n = 0; #1; chk("R8 ce_n high float", dq_oe, 0);
    oe_n = 1;
    // unrecognised (R9)
    wr(17'h0, 8'h55); rd("R9 unknown -> read", 17'h5);
    // erase set-up then other command (R2)
    wr(17'h0, 8'h20); wr(17'h0, 8'h40);
    rd("R2 second byte decoded fresh", 17'h5);
    wr(17'h0, 8'hFF); wr(17'h0, 8'hC0);
    rd("R6 pvfy after read", 17'h3);
    // erase with hv low: no change (R7)
    hv_en = 0;
    wr(17'h0, 8'h20); wr(17'h0, 8'h20);
    rd("R7 erase hv low", 17'h5);
    wr(17'h5, 8'hA0); rd("R7 evfy hv low", 17'h9);
    wr(17'h0, 8'h40); wr(17'h6, 8'h00);
    rd("R7 program hv low", 17'h6);
    hv_en = 1;
    // erase, held through reads (R3), then verify (R4, R10)
    wr(17'h0, 8'h40); wr(17'h7, 8'h3C);
    wr(17'h0, 8'h20); wr(17'h0, 8'h20);
    rd("R3 erase held", 17'h7);
    rd("R3 erase still held", 17'h5);
    wr(17'h7, 8'hA0);
    rd("R4/R10 erase verify", 17'h12);
    // same-cycle: oe_n held low across write
    wr(17'h0, 8'h40);
    @(negedge clk); oe_n = 0; ce_n = 0; addr = 17'h20; we_n = 0;
    @(negedge clk); we_n = 1; dq_in = 8'h81;
    @(posedge clk); model_wr(8'h20, 8'h81, hv_en);
    #1; addr = 17'h20; #1;
    chk("R5 read right after program start", dq_out, exp_rd(17'h20));
    chk("R5 prog_on right after start", prog_on, 1);
    @(negedge clk); oe_n = 1; ce_n = 1;

    // random
    for (int n = 0; n < 400; n++) begin
      logic [7:0] d;
      int pick;
      pick = $urandom_range(0, 6);
      case (pick)
        0: d = 8'h20; 1: d = 8'hA0; 2: d = 8'h40; 3: d = 8'hC0;
        4: d = 8'h20; 5: d = 8'h40; default: d = 8'($urandom);
      endcase
      hv_en = ($urandom_range(0, 7) != 0);
      wr(AW'($urandom), d);
      if (m_st == 4) wr(AW'($urandom_range(0, 31)), 8'($urandom));
      rd("R1-random read", AW'($urandom_range(0, 31)));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule